// File: doc/BRIEF.md
# Seconds counter with match alarm

This block is a memory-mapped real-time seconds counter for a chip's peripheral bus. A 32-bit count moves up by one each second. The second comes from a prescaler that counts pulses of a 32768 Hz reference, delivered as single-cycle enables in the bus clock domain. Software can preset the count by writing a dedicated load register. The current count is read from a separate read-only data register.

A match register holds an alarm time. On the second on which the count steps to the match value, a raw alarm flag is set. This happens whatever the state of the mask. The interrupt line is the raw flag gated by a mask bit, and software removes the flag by writing a one to a clear register.

Three small state machines shape the block:
- **Bus phase machine.** Its states are `BUS_IDLE`, `BUS_SETUP` and `BUS_ACCESS`.
  - `BUS_IDLE` goes to `BUS_SETUP` when select is high and enable is low.
  - `BUS_SETUP` goes to `BUS_ACCESS` when select and enable are both high. This is the commit transition.
  - `BUS_SETUP` stays in `BUS_SETUP` while select is high and enable is still low.
  - `BUS_SETUP` falls back to `BUS_IDLE` when select drops.
  - `BUS_ACCESS` goes to `BUS_SETUP` on a back-to-back setup. Otherwise it returns to `BUS_IDLE`.
- **Counter run machine.** Its states are `CNT_HALT` and `CNT_RUN`. It holds the control enable.
  - A control write with bit 0 set moves it from `CNT_HALT` to `CNT_RUN`.
  - A control write with bit 0 clear moves it from `CNT_RUN` to `CNT_HALT`.
  - In `CNT_HALT` the prescaler is held at zero.
- **Alarm flag.** It has the two conditions idle and pending.
  - A match moves it to pending.
  - A clear write returns it to idle.
  - A match and a clear in the same cycle leave it pending.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset, every readable register reads zero (count, match, control, mask, raw status, masked status) and `irq` is low.
- R2: The count steps up by one on every PRESCALE-th `ref_tick` while control bit 0 is 1. While control bit 0 is 0 the count holds, and the prescaler is cleared, so each fresh enable starts a full second. The count wraps from all ones to zero.
- R3: A write to word index 2 (byte offset 0x08, load) sets the count to the written data from the next cycle. A load wins over a second tick in the same cycle, and that tick raises no alarm.
- R4: Word index 1 (byte offset 0x04, match) and word index 3 (0x0C, control, bit 0 only) read back what was written. Word index 4 (0x10, mask, bit 0 only) also reads back what was written.
- R5: Raw status bit 0 at word index 5 (0x14) is set on the second tick where the count becomes equal to the match value. It is set whether the mask is 0 or 1.
- R6: Masked status bit 0 at word index 6 (0x18) reads raw AND mask, and `irq` equals that bit.
- R7: Writing 1 to bit 0 of word index 7 (0x1C, clear) clears the raw flag. Writing 0 there leaves it unchanged.
- R8: If the alarm sets in the same cycle as a clear write, the raw flag ends set.
- R9: Writes to word indices 0, 5 and 6 are ignored. Word indices 2 and 7 read as zero.
- R10: A register write takes effect only in the access phase: the cycle with select and enable high that follows a setup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference period (32768 Hz) |
| sel | input | 1 | Bus select |
| enable | input | 1 | Bus enable (access phase) |
| write | input | 1 | 1 = write transfer |
| addr | input | 3 | Word index (byte offset / 4) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while `sel` is high, zero otherwise |
| irq | output | 1 | Level alarm interrupt |

## Verification
The assertions check the following on every cycle:
- the one-step advance of the count on a second tick, and the hold of the count while halted;
- load precedence over a tick;
- alarm set on a match, including when a clear arrives in the same cycle;
- removal of the flag by a clear;
- the interrupt never rising while the mask is 0.

The bench's scenarios cover the things a single-cycle property cannot see:
- the prescaler's phase over many reference pulses;
- the count wrapping across zero;
- a sweep of match distances against both mask settings;
- the read-back values and zero reads at each address;
- the writes that must be ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_IDX_W = 3;

    // Word indices of the register file; byte offset = index * 4.
    localparam logic [REG_IDX_W-1:0] RG_COUNT = 3'd0;
    localparam logic [REG_IDX_W-1:0] RG_MATCH = 3'd1;
    localparam logic [REG_IDX_W-1:0] RG_LOAD  = 3'd2;
    localparam logic [REG_IDX_W-1:0] RG_CTRL  = 3'd3;
    localparam logic [REG_IDX_W-1:0] RG_MASK  = 3'd4;
    localparam logic [REG_IDX_W-1:0] RG_RAW   = 3'd5;
    localparam logic [REG_IDX_W-1:0] RG_MIS   = 3'd6;
    localparam logic [REG_IDX_W-1:0] RG_CLR   = 3'd7;
    localparam int NUM_REGS = 1 << REG_IDX_W;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_e;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic enable,
    input  logic write,
    output logic wr_commit
);
    bus_state_e state_q;
    bus_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (sel && !enable) state_d = BUS_SETUP;
            end
            BUS_SETUP: begin
                if (!sel)        state_d = BUS_IDLE;
                else if (enable) state_d = BUS_ACCESS;
            end
            BUS_ACCESS: begin
                if (sel && !enable) state_d = BUS_SETUP;
                else                state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // Outputs: one write strobe per transfer, on the commit transition
    always_comb begin
        wr_commit = 1'b0;
        unique case (state_q)
            BUS_SETUP:  wr_commit = sel && enable && write;
            BUS_IDLE,
            BUS_ACCESS: wr_commit = 1'b0;
            default:    wr_commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic ctrl_we,
    input  logic ctrl_bit,
    output logic en_q,
    output logic sec_tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [PRE_W-1:0] pre_q;
    logic             at_last;

    // State register: the run state is the control enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (ctrl_we && ctrl_bit)  state_d = CNT_RUN;
            CNT_RUN:  if (ctrl_we && !ctrl_bit) state_d = CNT_HALT;
            default:  state_d = CNT_HALT;
        endcase
    end

    // Outputs
    always_comb begin
        at_last  = (pre_q == PRE_LAST);
        en_q     = (state_q == CNT_RUN);
        sec_tick = en_q && ref_tick && at_last;
    end

    // Reference-pulse divider, held at zero while halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            unique case (state_q)
                CNT_HALT: pre_q <= '0;
                CNT_RUN: begin
                    if (ref_tick) pre_q <= at_last ? '0 : pre_q + 1'b1;
                end
                default: pre_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              load_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] count_q,
    output logic              raw_q,
    output logic              alarm_hit
);
    logic [DATA_W-1:0] count_inc;
    logic              clr_req;

    always_comb begin
        count_inc = count_q + 1'b1;
        alarm_hit = sec_tick && !load_we && (count_inc == match_q);
        clr_req   = clr_we && wdata[0];
    end

    // Count: a load takes precedence over a second tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_we) begin
            count_q <= wdata;
        end else if (sec_tick) begin
            count_q <= count_inc;
        end
    end

    // Raw alarm flag: a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (alarm_hit) begin
            raw_q <= 1'b1;
        end else if (clr_req) begin
            raw_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter
    import rtc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 32768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick,
    input  logic                 sel,
    input  logic                 enable,
    input  logic                 write,
    input  logic [REG_IDX_W-1:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq
);
    logic                wr_commit;
    logic [NUM_REGS-1:0] reg_we;
    logic                load_we;
    logic                clr_we;
    logic                ctrl_we;
    logic                en_q;
    logic                sec_tick;
    logic [DATA_W-1:0]   count_q;
    logic [DATA_W-1:0]   match_q;
    logic                mask_q;
    logic                raw_q;
    logic                masked;
    logic                alarm_hit;
    logic [DATA_W-1:0]   rd_mux;

    rtc_bus_fsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .enable    (enable),
        .write     (write),
        .wr_commit (wr_commit)
    );

    // One write strobe per word index
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign reg_we[g] = wr_commit && (addr == REG_IDX_W'(g));
    end

    assign load_we = reg_we[RG_LOAD];
    assign clr_we  = reg_we[RG_CLR];
    assign ctrl_we = reg_we[RG_CTRL];

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .ctrl_we  (ctrl_we),
        .ctrl_bit (wdata[0]),
        .en_q     (en_q),
        .sec_tick (sec_tick)
    );

    rtc_count_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .load_we   (load_we),
        .clr_we    (clr_we),
        .wdata     (wdata),
        .match_q   (match_q),
        .count_q   (count_q),
        .raw_q     (raw_q),
        .alarm_hit (alarm_hit)
    );

    // Match and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            mask_q  <= 1'b0;
        end else begin
            if (reg_we[RG_MATCH]) match_q <= wdata;
            if (reg_we[RG_MASK])  mask_q  <= wdata[0];
        end
    end

    assign masked = raw_q && mask_q;
    assign irq    = masked;

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (addr)
            RG_COUNT: rd_mux = count_q;
            RG_MATCH: rd_mux = match_q;
            RG_CTRL:  rd_mux = {{(DATA_W-1){1'b0}}, en_q};
            RG_MASK:  rd_mux = {{(DATA_W-1){1'b0}}, mask_q};
            RG_RAW:   rd_mux = {{(DATA_W-1){1'b0}}, raw_q};
            RG_MIS:   rd_mux = {{(DATA_W-1){1'b0}}, masked};
            RG_LOAD,
            RG_CLR:   rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    assign rdata = sel ? rd_mux : '0;
endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              load_we,
    input logic              clr_we,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] match_q,
    input logic              mask_q,
    input logic              raw_q,
    input logic              en_q,
    input logic              irq
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_we) |=> (count_q == $past(count_q) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !load_we) |=> (count_q == $past(count_q)));

    p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count_q == $past(wdata)));

    p_alarm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_we && (count_q + 1'b1 == match_q)) |=> raw_q);

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_we && (count_q + 1'b1 == match_q) && clr_we && wdata[0])
        |=> raw_q);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[0] && !(sec_tick && !load_we && (count_q + 1'b1 == match_q)))
        |=> !raw_q);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq);
endmodule

bind rtc_alarm_counter rtc_alarm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .load_we  (load_we),
    .clr_we   (clr_we),
    .wdata    (wdata),
    .count_q  (count_q),
    .match_q  (match_q),
    .mask_q   (mask_q),
    .raw_q    (raw_q),
    .en_q     (en_q),
    .irq      (irq)
);

// File: tb/tb_rtc_alarm_counter.sv
module tb_rtc_alarm_counter;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int P  = 4;

    localparam logic [2:0] I_COUNT = 3'd0, I_MATCH = 3'd1, I_LOAD = 3'd2, I_CTRL = 3'd3;
    localparam logic [2:0] I_MASK  = 3'd4, I_RAW   = 3'd5, I_MIS  = 3'd6, I_CLR  = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          sel = 1'b0, enable = 1'b0, write = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model
    logic [DW-1:0] m_cnt, m_match;
    int            m_pre;
    logic          m_en, m_mask, m_raw;

    rtc_alarm_counter #(.DATA_W(DW), .PRESCALE(P)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sel(sel), .enable(enable),
        .write(write), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One model cycle: write effect and reference pulse at the same edge
    task automatic model_cycle(input logic we, input logic [2:0] idx,
                               input logic [DW-1:0] d, input logic tk);
        logic ld, sec, hit;
        ld  = we && idx == I_LOAD;
        sec = tk && m_en && m_pre == P-1;
        if (m_en && tk) m_pre = (m_pre == P-1) ? 0 : m_pre + 1;
        hit = sec && !ld && (m_cnt + 1'b1) == m_match;
        if (ld) m_cnt = d;
        else if (sec) m_cnt = m_cnt + 1'b1;
        if (hit) m_raw = 1'b1;
        else if (we && idx == I_CLR && d[0]) m_raw = 1'b0;
        if (we && idx == I_MATCH) m_match = d;
        if (we && idx == I_MASK)  m_mask  = d[0];
        if (we && idx == I_CTRL) begin
            m_en = d[0];
            if (!m_en) m_pre = 0;
        end
    endtask

    task automatic bus_wr(input logic [2:0] idx, input logic [DW-1:0] d, input logic tk);
        @(negedge clk);
        sel = 1; enable = 0; write = 1; addr = idx; wdata = d;
        @(negedge clk);
        enable = 1; ref_tick = tk;
        @(negedge clk);
        sel = 0; enable = 0; write = 0; ref_tick = 0;
        model_cycle(1'b1, idx, d, tk);
    endtask

    task automatic bus_rd(input logic [2:0] idx, output logic [DW-1:0] d);
        @(negedge clk);
        sel = 1; enable = 0; write = 0; addr = idx;
        @(negedge clk);
        enable = 1;
        #1 d = rdata;
        @(negedge clk);
        sel = 0; enable = 0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1;
            @(negedge clk); ref_tick = 0;
            model_cycle(1'b0, 3'd0, '0, 1'b1);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        bus_rd(idx, v);
        chk(req, v, exp);
    endtask

    // Bring the prescaler to its last phase (only while running)
    task automatic align_last();
        while (m_pre != P-1) pulse(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] base;
        m_cnt = '0; m_match = '0; m_pre = 0; m_en = 0; m_mask = 0; m_raw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_chk("R1 count", I_COUNT, '0);
        rd_chk("R1 match", I_MATCH, '0);
        rd_chk("R1 ctrl", I_CTRL, '0);
        rd_chk("R1 mask", I_MASK, '0);
        rd_chk("R1 raw", I_RAW, '0);
        rd_chk("R1 masked", I_MIS, '0);
        chk("R1 irq", {31'b0, irq}, '0);

        // R2 halted: reference pulses do not move the count
        pulse(3*P);
        rd_chk("R2 halted count", I_COUNT, '0);

        // R4 read-back
        bus_wr(I_MATCH, 32'hA5A5_0F0F, 0);
        rd_chk("R4 match", I_MATCH, 32'hA5A5_0F0F);
        bus_wr(I_MASK, 32'hFFFF_FFFF, 0);
        rd_chk("R4 mask", I_MASK, 32'h1);
        bus_wr(I_MASK, 32'h0, 0);
        bus_wr(I_CTRL, 32'hFFFF_FFFF, 0);
        rd_chk("R4 ctrl", I_CTRL, 32'h1);

        // R3 load
        bus_wr(I_LOAD, 32'h0000_1234, 0);
        rd_chk("R3 load", I_COUNT, 32'h0000_1234);

        // R2 stepping one per P pulses
        for (int s = 0; s < 3; s++) begin
            pulse(P);
            rd_chk("R2 step", I_COUNT, m_cnt);
        end

        // R9 read-only and zero-read registers
        bus_wr(I_COUNT, 32'hDEAD_BEEF, 0);
        rd_chk("R9 count write ignored", I_COUNT, m_cnt);
        bus_wr(I_RAW, 32'h1, 0);
        rd_chk("R9 raw write ignored", I_RAW, '0);
        bus_wr(I_MIS, 32'h1, 0);
        rd_chk("R9 masked write ignored", I_MIS, '0);
        rd_chk("R9 load reads zero", I_LOAD, '0);
        rd_chk("R9 clear reads zero", I_CLR, '0);

        // R10 enable without a setup phase does not write
        @(negedge clk);
        sel = 1; enable = 1; write = 1; addr = I_MATCH; wdata = 32'h7777_7777;
        @(negedge clk);
        sel = 0; enable = 0; write = 0;
        rd_chk("R10 no setup no write", I_MATCH, 32'hA5A5_0F0F);

        // R5 R6 sweep over match distance and mask, crossing the count wrap
        for (int mk = 0; mk < 2; mk++) begin
            bus_wr(I_MASK, DW'(mk), 0);
            for (int d = 1; d <= 6; d++) begin
                base = 32'hFFFF_FFFF - 32'd2;
                bus_wr(I_LOAD, base, 0);
                bus_wr(I_MATCH, base + DW'(d), 0);
                bus_wr(I_CLR, 32'h1, 0);
                for (int s = 0; s < d; s++) begin
                    pulse(P);
                    rd_chk("R2 sweep count", I_COUNT, m_cnt);
                    rd_chk("R5 raw", I_RAW, {31'b0, m_raw});
                    rd_chk("R6 masked", I_MIS, {31'b0, m_raw & m_mask});
                    chk("R6 irq", {31'b0, irq}, {31'b0, m_raw & m_mask});
                end
                chk("R5 alarm reached", {31'b0, m_raw}, 32'h1);
            end
        end

        // R7 clear with 0 has no effect, with 1 clears
        bus_wr(I_CLR, 32'h0, 0);
        rd_chk("R7 clear zero no effect", I_RAW, 32'h1);
        bus_wr(I_CLR, 32'h1, 0);
        rd_chk("R7 clear one", I_RAW, 32'h0);
        chk("R7 irq low", {31'b0, irq}, '0);

        // R8 set and clear in the same cycle
        align_last();
        bus_wr(I_MATCH, m_cnt + 1'b1, 0);
        bus_wr(I_CLR, 32'h1, 1);
        rd_chk("R8 set wins raw", I_RAW, 32'h1);
        rd_chk("R8 count stepped", I_COUNT, m_cnt);

        // R3 load beats a tick; no alarm from that tick
        bus_wr(I_CLR, 32'h1, 0);
        align_last();
        bus_wr(I_MATCH, 32'h0000_0051, 0);
        bus_wr(I_LOAD, 32'h0000_0050, 1);
        rd_chk("R3 load beats tick", I_COUNT, 32'h0000_0050);
        rd_chk("R3 no alarm on load", I_RAW, 32'h0);

        // R2 disable clears prescaler; re-enable needs a full P pulses
        pulse(2);
        bus_wr(I_CTRL, 32'h0, 0);
        rd_chk("R4 ctrl off", I_CTRL, 32'h0);
        pulse(P);
        rd_chk("R2 disabled hold", I_COUNT, m_cnt);
        bus_wr(I_CTRL, 32'h1, 0);
        pulse(P-1);
        rd_chk("R2 fresh second not yet", I_COUNT, 32'h0000_0050);
        pulse(1);
        rd_chk("R2 fresh second done", I_COUNT, 32'h0000_0051);
        rd_chk("R5 alarm after restart", I_RAW, 32'h1);

        finish_run();
    end
endmodule